// File: doc/BRIEF.md
# Indirect Jump Target Generator

This block works out the new program counter for an indirect jump. It takes a 16-bit pointer, an 8-bit X index, a choice between the plain and the X-indexed pointer forms, and a choice between legacy and enhanced behaviour. It makes two byte reads through a read port with combinational return data. The first read fetches the low target byte and the second fetches the high target byte. It then presents the 16-bit target together with a one-cycle done pulse.

Legacy behaviour keeps the old page-wrap defect. The high-byte fetch never carries out of the pointer's 256-byte page. When this defect moves the fetch, a diagnostic flag rises together with the offending pointer value. Enhanced behaviour carries correctly, takes one more cycle, and also accepts the X-indexed form. An X-indexed request in legacy behaviour is refused with an error pulse. A refused request makes no memory read and gives no target.

Cycle numbering: the clock period in which `start_i` is sampled high is period 1. Later periods count up from there.

Top module: `ijmp_target_gen`

## Requirements
- R1: In legacy mode the low target byte is read from the pointer P. The high byte is read from {P[15:8], P[7:0]+1 mod 256}, so the high address never leaves the pointer's page.
- R2: A legacy plain jump asserts `done_o` in period 5. The low read happens in period 3 and the high read in period 4.
- R3: `wrap_hit_o` is high, with `wrap_ptr_o` equal to P, only in the done period of a legacy jump whose pointer low byte is 0xFF. In every other period, and for every other jump, it is low.
- R4: In enhanced mode the high byte is read from P+1 with a full 16-bit carry, wrapping modulo 65536. `done_o` rises in period 6, and the reads happen in periods 4 and 5.
- R5: The X-indexed form (`indexed_i`=1) in enhanced mode uses E = (P + X) mod 65536 as the pointer. It reads E and E+1 (mod 65536) and completes in period 6.
- R6: `target_o` equals {high byte, low byte} in the period in which `done_o` is high, and `done_o` lasts exactly one period.
- R7: A request with `indexed_i`=1 and `enhanced_i`=0 raises `err_o` for exactly period 2. It makes no read and raises no `done_o`.
- R8: `start_i` is ignored while a jump is in progress. A second request during a jump changes neither that jump's target nor its timing.
- R9: After reset `busy_o`, `done_o`, `rd_en_o`, `err_o` and `wrap_hit_o` are all low.
- R10: Every accepted jump makes exactly two reads, low address first and high address second, each one cycle wide with `rd_en_o` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request a jump (taken when idle) |
| ptr_i | input | 16 | Pointer operand |
| xidx_i | input | 8 | X index value |
| indexed_i | input | 1 | 1 selects the X-indexed pointer form |
| enhanced_i | input | 1 | 1 selects enhanced mode, 0 legacy |
| rd_en_o | output | 1 | Memory read strobe |
| rd_addr_o | output | 16 | Memory read address |
| rd_data_i | input | 8 | Read data, valid in the same cycle as the address |
| busy_o | output | 1 | A jump is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| target_o | output | 16 | Jump target, valid while done_o is high |
| wrap_hit_o | output | 1 | Legacy page-wrap defect changed the high fetch address |
| wrap_ptr_o | output | 16 | Pointer that triggered the page wrap (zero otherwise) |
| err_o | output | 1 | Refused request (indexed form in legacy mode) |

## Verification
Some properties are checked on every cycle. A done pulse never lasts two cycles. The high read always follows the low read, and done always follows the high read. A legacy high fetch stays in the pointer's page. The wrap flag appears only with done. An error pulse never coincides with activity. The bench sweeps every pointer low byte across changing pages in three forms and also covers the 0xFFFF carry and index overflow. These sweeps are the only place where the target values, exact period counts, read addresses and the ignoring of a second request can be shown.

// File: rtl/ijt_pkg.sv
package ijt_pkg;

  localparam int unsigned ADDR_W = 16;
  localparam int unsigned DATA_W = 8;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] byte_t;

  // Pointer after optional indexing, wrapping modulo the address space.
  function automatic addr_t ijt_eff_ptr(addr_t p, byte_t x, logic use_x);
    addr_t sum;
    sum = p + addr_t'(x);
    return use_x ? sum : p;
  endfunction

  // Address of the high target byte; legacy stays inside the pointer page.
  function automatic addr_t ijt_hi_addr(addr_t p, logic legacy);
    byte_t lo_next;
    lo_next = p[DATA_W-1:0] + byte_t'(1);
    if (legacy) return {p[ADDR_W-1:DATA_W], lo_next};
    return p + addr_t'(1);
  endfunction

  // True when the legacy page wrap moves the high fetch.
  function automatic logic ijt_page_slip(addr_t p, logic legacy);
    return legacy && (&p[DATA_W-1:0]);
  endfunction

endpackage

// File: rtl/ijt_sequencer.sv
module ijt_sequencer #(
  parameter int unsigned LEG_CYC = 5,
  parameter int unsigned ENH_CYC = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic indexed,
  input  logic enhanced,
  output logic load,
  output logic busy,
  output logic fault,
  output logic phase_lo,
  output logic phase_hi,
  output logic phase_done
);

  localparam int unsigned MAX_CYC = (LEG_CYC > ENH_CYC) ? LEG_CYC : ENH_CYC;
  localparam int unsigned CW      = $clog2(MAX_CYC + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim_q;
  logic          accept;
  logic          reject;

  assign accept = start && !busy;
  assign reject = accept && indexed && !enhanced;
  assign load   = accept && !reject;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt_q <= '0;
      lim_q <= '0;
      fault <= 1'b0;
    end else begin
      fault <= reject;
      if (load) begin
        busy  <= 1'b1;
        cnt_q <= CW'(2);
        lim_q <= enhanced ? CW'(ENH_CYC) : CW'(LEG_CYC);
      end else if (busy) begin
        if (cnt_q == lim_q) busy <= 1'b0;
        else                cnt_q <= cnt_q + CW'(1);
      end
    end
  end

  assign phase_lo   = busy && (cnt_q == lim_q - CW'(2));
  assign phase_hi   = busy && (cnt_q == lim_q - CW'(1));
  assign phase_done = busy && (cnt_q == lim_q);

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    phase_done |=> !phase_done);
  assert_hi_after_lo_R10: assert property (@(posedge clk) disable iff (!rst_n)
    phase_hi |-> $past(phase_lo));
  assert_done_after_hi_R10: assert property (@(posedge clk) disable iff (!rst_n)
    phase_done |-> $past(phase_hi));
  assert_fault_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (!busy && !phase_lo && !phase_hi));
  assert_limit_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !phase_done) |=> $stable(lim_q));

endmodule

// File: rtl/ijt_ptr_stage.sv
module ijt_ptr_stage
  import ijt_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  addr_t ptr,
  input  byte_t xidx,
  input  logic  indexed,
  input  logic  enhanced,
  output addr_t lo_addr,
  output addr_t hi_addr,
  output logic  slip
);

  addr_t eff_q;
  logic  legacy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eff_q    <= '0;
      legacy_q <= 1'b0;
    end else if (load) begin
      eff_q    <= ijt_eff_ptr(ptr, xidx, indexed && enhanced);
      legacy_q <= !enhanced;
    end
  end

  assign lo_addr = eff_q;
  assign hi_addr = ijt_hi_addr(eff_q, legacy_q);
  assign slip    = ijt_page_slip(eff_q, legacy_q);

  assert_legacy_page_R1: assert property (@(posedge clk) disable iff (!rst_n)
    legacy_q |-> (hi_addr[ADDR_W-1:DATA_W] == lo_addr[ADDR_W-1:DATA_W]));

endmodule

// File: rtl/ijt_byte_join.sv
module ijt_byte_join
  import ijt_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  phase_lo,
  input  logic  phase_hi,
  input  byte_t rd_data,
  output addr_t target
);

  byte_t lo_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q   <= '0;
      target <= '0;
    end else begin
      if (phase_lo) lo_q <= rd_data;
      if (phase_hi) target <= {rd_data, lo_q};
    end
  end

endmodule

// File: rtl/ijmp_target_gen.sv
module ijmp_target_gen
  import ijt_pkg::*;
#(
  parameter int unsigned LEG_CYC = 5,
  parameter int unsigned ENH_CYC = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic [15:0] ptr_i,
  input  logic [7:0]  xidx_i,
  input  logic        indexed_i,
  input  logic        enhanced_i,
  output logic        rd_en_o,
  output logic [15:0] rd_addr_o,
  input  logic [7:0]  rd_data_i,
  output logic        busy_o,
  output logic        done_o,
  output logic [15:0] target_o,
  output logic        wrap_hit_o,
  output logic [15:0] wrap_ptr_o,
  output logic        err_o
);

  logic  load_w;
  logic  busy_w;
  logic  fault_w;
  logic  ph_lo_w;
  logic  ph_hi_w;
  logic  ph_done_w;
  addr_t lo_addr_w;
  addr_t hi_addr_w;
  logic  slip_w;
  addr_t target_w;

  ijt_sequencer #(.LEG_CYC(LEG_CYC), .ENH_CYC(ENH_CYC)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start_i),
    .indexed    (indexed_i),
    .enhanced   (enhanced_i),
    .load       (load_w),
    .busy       (busy_w),
    .fault      (fault_w),
    .phase_lo   (ph_lo_w),
    .phase_hi   (ph_hi_w),
    .phase_done (ph_done_w)
  );

  ijt_ptr_stage u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load_w),
    .ptr      (ptr_i),
    .xidx     (xidx_i),
    .indexed  (indexed_i),
    .enhanced (enhanced_i),
    .lo_addr  (lo_addr_w),
    .hi_addr  (hi_addr_w),
    .slip     (slip_w)
  );

  ijt_byte_join u_join (
    .clk      (clk),
    .rst_n    (rst_n),
    .phase_lo (ph_lo_w),
    .phase_hi (ph_hi_w),
    .rd_data  (rd_data_i),
    .target   (target_w)
  );

  assign rd_en_o    = ph_lo_w || ph_hi_w;
  assign rd_addr_o  = ph_hi_w ? hi_addr_w : (ph_lo_w ? lo_addr_w : '0);
  assign busy_o     = busy_w;
  assign done_o     = ph_done_w;
  assign target_o   = target_w;
  assign wrap_hit_o = ph_done_w && slip_w;
  assign wrap_ptr_o = wrap_hit_o ? lo_addr_w : '0;
  assign err_o      = fault_w;

  assert_wrap_with_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_hit_o |-> done_o);
  assert_no_read_on_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (!rd_en_o && !done_o));
  assert_read_one_hot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ph_lo_w, ph_hi_w, ph_done_w}));

endmodule

// File: tb/ijmp_target_gen_bench.sv
module ijmp_target_gen_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] ptr_i = '0;
  logic [7:0]  xidx_i = '0;
  logic        indexed_i = 1'b0;
  logic        enhanced_i = 1'b0;
  logic        rd_en_o;
  logic [15:0] rd_addr_o;
  logic [7:0]  rd_data_i;
  logic        busy_o;
  logic        done_o;
  logic [15:0] target_o;
  logic        wrap_hit_o;
  logic [15:0] wrap_ptr_o;
  logic        err_o;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  function automatic logic [7:0] mem_byte(logic [15:0] a);
    return (a[7:0] * 8'd7) ^ a[15:8] ^ 8'hA5;
  endfunction

  assign rd_data_i = mem_byte(rd_addr_o);

  ijmp_target_gen u_ijmp_target_gen (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .ptr_i(ptr_i), .xidx_i(xidx_i),
    .indexed_i(indexed_i), .enhanced_i(enhanced_i), .rd_en_o(rd_en_o),
    .rd_addr_o(rd_addr_o), .rd_data_i(rd_data_i), .busy_o(busy_o), .done_o(done_o),
    .target_o(target_o), .wrap_hit_o(wrap_hit_o), .wrap_ptr_o(wrap_ptr_o), .err_o(err_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_jump(input logic [15:0] p, input logic [7:0] x, input bit idx,
                         input bit enh, input bit restart);
    logic [15:0] eff, hi, exp_tgt, got_tgt, got_wptr;
    logic [15:0] raddr [0:3];
    int per, reads, done_per, done_cnt, err_per, err_cnt, exp_cyc;
    bit refuse, exp_wrap, got_wrap;
    refuse   = idx && !enh;
    eff      = (enh && idx) ? 16'((32'(p) + 32'(x)) % 65536) : p;
    hi       = enh ? 16'((32'(eff) + 1) % 65536) : {eff[15:8], 8'((eff[7:0] + 1) % 256)};
    exp_tgt  = {mem_byte(hi), mem_byte(eff)};
    exp_cyc  = enh ? 6 : 5;
    exp_wrap = !enh && (eff[7:0] == 8'hFF);
    reads = 0; done_per = 0; done_cnt = 0; err_per = 0; err_cnt = 0;
    got_tgt = '0; got_wrap = 1'b0; got_wptr = '0;
    @(negedge clk);
    ptr_i = p; xidx_i = x; indexed_i = idx; enhanced_i = enh; start_i = 1'b1;
    per = 1;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      per++;
      start_i = 1'b0;
      if (restart && per == 3) begin
        start_i = 1'b1; ptr_i = p ^ 16'h5555; xidx_i = 8'h33; indexed_i = 1'b0;
        enhanced_i = !enh;
      end
      if (rd_en_o) begin
        if (reads < 4) raddr[reads] = rd_addr_o;
        reads++;
      end
      if (done_o) begin
        done_cnt++; done_per = per;
        got_tgt = target_o; got_wrap = wrap_hit_o; got_wptr = wrap_ptr_o;
      end
      if (wrap_hit_o && !done_o) got_wrap = 1'b1;
      if (err_o) begin err_cnt++; err_per = per; end
    end
    start_i = 1'b0;
    if (refuse) begin
      chk(err_cnt == 1 && err_per == 2, "R7 err pulse period", err_per, 2);
      chk(reads == 0, "R7 no reads on refusal", reads, 0);
      chk(done_cnt == 0, "R7 no done on refusal", done_cnt, 0);
    end else begin
      chk(err_cnt == 0, "R7 no err on accepted jump", err_cnt, 0);
      chk(done_cnt == 1, "R6 single done pulse", done_cnt, 1);
      chk(done_per == exp_cyc, enh ? (idx ? "R5 cycles" : "R4 cycles") : "R2 cycles",
          done_per, exp_cyc);
      chk(got_tgt == exp_tgt, restart ? "R8 target unchanged" : "R6 target", got_tgt, exp_tgt);
      chk(reads == 2, "R10 read count", reads, 2);
      if (reads == 2) begin
        chk(raddr[0] == eff, idx ? "R5 low read address" : "R1 low read address",
            raddr[0], eff);
        chk(raddr[1] == hi, enh ? "R4 high read address" : "R1 high read address",
            raddr[1], hi);
      end
      chk(got_wrap == exp_wrap, "R3 wrap flag", got_wrap, exp_wrap);
      if (exp_wrap) chk(got_wptr == p, "R3 wrap pointer", got_wptr, p);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy_o && !done_o && !rd_en_o && !err_o && !wrap_hit_o, "R9 reset idle",
        {busy_o, done_o, rd_en_o, err_o, wrap_hit_o}, 0);
    for (int lo = 0; lo < 256; lo++) begin
      logic [15:0] p;
      p = {8'((lo * 37 + 1) % 256), 8'(lo)};
      do_jump(p, 8'h00, 1'b0, 1'b0, 1'b0);
      do_jump(p, 8'h00, 1'b0, 1'b1, 1'b0);
      do_jump(p, 8'((lo * 13) % 256), 1'b1, 1'b1, 1'b0);
      if (lo % 32 == 0) do_jump(p, 8'h10, 1'b1, 1'b0, 1'b0);
    end
    do_jump(16'hFFFF, 8'h00, 1'b0, 1'b1, 1'b0);
    do_jump(16'hFFFF, 8'h00, 1'b0, 1'b0, 1'b0);
    do_jump(16'hFFF0, 8'h20, 1'b1, 1'b1, 1'b0);
    do_jump(16'hFFFE, 8'h01, 1'b1, 1'b1, 1'b0);
    do_jump(16'h12FF, 8'h00, 1'b1, 1'b1, 1'b0);
    do_jump(16'h34FF, 8'h00, 1'b0, 1'b0, 1'b1);
    do_jump(16'h5610, 8'h00, 1'b0, 1'b1, 1'b1);
    do_jump(16'h7780, 8'h90, 1'b1, 1'b1, 1'b1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule